// File: doc/BRIEF.md
# Paged Window Address Translator

This block sits behind a host memory-mapped region and turns host offsets into byte addresses in a 32-bit internal address space. The region holds three windows, each with its own programmable base. Window A and window C are small and fixed in place. The last part of the region, window B, is the largest window. It is moved by paging, that is by loading a new base that is aligned to its power-of-two size. A 32-byte slice between window C and window B returns a read-only copy of configuration registers and never reaches the internal bus.

Each host access carries an offset, a size (byte, halfword or word), a direction and a flag that selects the alternate I/O-space path. The block decodes the access, adds the base of the selected window and registers the result. It then drives a simple request/acknowledge internal bus. Bad accesses and accesses to the mirror slice are answered locally. The window bases and the mirrored configuration words are loaded through a configuration-style write port. The host sees one acknowledge pulse per accepted request, with a data word and an error flag.

Top module: `bar_window_xlate`

## Requirements
- R1: After reset all three window bases are zero and neither `ib_req` nor `host_ack` is asserted. A word access at host offset 0x010 then produces internal address 0x0000_0010, and an access at offset 0x080 produces internal address 0x0000_0000.
- R2: Host offsets 0x000 to 0x057 map to internal address base_A + offset.
- R3: Host offsets 0x058 to 0x05F map to internal address base_C + (offset - 0x058).
- R4: Host offsets 0x060 to 0x07F complete one cycle after the request with no internal bus request. A read returns the mirrored configuration word whose config address is (offset AND 0xFC). A write is ignored, so a later read returns the value it returned before.
- R5: Host offsets from 0x080 up to the end of the region map to internal address base_B + (offset - 0x080).
- R6: A configuration write stores a full 32-bit word. Address 0x40 loads base_A, 0x44 loads base_C, and 0x60 + 4*i (i = 0..7) loads mirror word i. Address 0x48 loads base_B, with the bits below the window B size (2^WINB_LOG2, 4096 by default) cleared.
- R7: Byte enables come from the translated address bits [1:0] and the size code (0 = byte, 1 = halfword, 2 = word). A byte enables lane addr[1:0]. A halfword enables 4'b0011 or 4'b1100 according to addr[1]. A word enables 4'b1111. Data stays in its lane positions.
- R8: A halfword with addr[0] set, a word with addr[1:0] not zero, or the size code 3 is answered with `host_ack` and `host_err` together, and no internal bus request is made.
- R9: A translated address at or above 0xC000_0000, including a carry out of the 32-bit sum, is answered with an error and never appears on the internal bus. Internal addresses just below the limit are forwarded.
- R10: When `host_io` is set, only host offset bits [7:0] are used to decode and translate the access.
- R11: For a forwarded access, `ib_req`, `ib_addr`, `ib_be`, `ib_we` and `ib_wdata` become valid one cycle after the request is accepted. They stay unchanged until `ib_ack` is sampled. `host_ack` follows in the next cycle with no error, and a read returns `ib_rdata`.
- R12: A request is accepted only when no internal transaction is in flight and `host_ack` is low. A request raised at any other time is dropped and causes no later internal bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, a one-cycle pulse |
| host_we | input | 1 | 1 = write, 0 = read |
| host_io | input | 1 | Alternate I/O path: decode only offset bits [7:0] |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| host_offs | input | OFFS_W | Byte offset inside the host region |
| host_wdata | input | 32 | Write data, lane positioned |
| host_ack | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Error flag, valid with host_ack |
| host_rdata | output | 32 | Read data, valid with host_ack |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| ib_req | output | 1 | Internal bus request, held until ib_ack |
| ib_we | output | 1 | Internal bus direction |
| ib_addr | output | 32 | Internal byte address |
| ib_be | output | 4 | Internal byte enables |
| ib_wdata | output | 32 | Internal write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 32 | Internal read data, valid with ib_ack |

## Verification
Translation is tried with offsets at the first and last byte of window A, window C and window B, against distinct nonzero bases. A missed region boundary, a wrong subtracted origin or a missing base alignment therefore each gives a different wrong address. Byte, halfword and word accesses are placed in each byte lane, and misaligned and reserved-size accesses are mixed with them. I/O-path accesses use offsets whose upper bits would select a different window if they were not masked. Base values just below the target limit, and one that wraps past 32 bits, show whether the limit is compared against the full sum. Mirror reads, a mirror write followed by a read-back, a slow acknowledge and a request raised mid-transaction cover the local answers and the handshake.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int MIRR_WORDS = 8;
    localparam int MIRR_IDX_W = $clog2(MIRR_WORDS);

    // region boundaries inside the host window (exclusive upper ends)
    localparam logic [7:0] WIN_A_END = 8'h58;
    localparam logic [7:0] WIN_C_END = 8'h60;
    localparam logic [7:0] MIRR_END  = 8'h80;

    localparam logic [ADDR_W:0] TARGET_LIMIT = 33'h0_C000_0000;

    // configuration write map
    localparam logic [7:0] CFG_BASE_A  = 8'h40;
    localparam logic [7:0] CFG_BASE_C  = 8'h44;
    localparam logic [7:0] CFG_BASE_B  = 8'h48;
    localparam logic [7:0] CFG_MIRR_LO = 8'h60;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RGN_A,
        RGN_C,
        RGN_MIRR,
        RGN_B
    } region_e;

    typedef struct packed {
        region_e                 rgn;
        logic                    fault;
        logic [ADDR_W-1:0]       addr;
        logic [BE_W-1:0]         be;
        logic [MIRR_IDX_W-1:0]   mirr_idx;
    } xlate_t;

    function automatic logic [BE_W-1:0] lane_enables(acc_size_e sz, logic [1:0] lo);
        logic [BE_W-1:0] be;
        case (sz)
            SZ_BYTE: be = 4'b0001 << lo;
            SZ_HALF: be = 4'b0011 << {lo[1], 1'b0};
            default: be = 4'b1111;
        endcase
        return be;
    endfunction

    function automatic logic bad_shape(acc_size_e sz, logic [1:0] lo);
        logic bad;
        case (sz)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = lo[0];
            SZ_WORD: bad = |lo;
            default: bad = 1'b1;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/bwx_cfg_regs.sv
module bwx_cfg_regs
    import bwx_pkg::*;
#(
    parameter int WINB_LOG2 = 12
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_we,
    input  logic [7:0]                          cfg_addr,
    input  logic [DATA_W-1:0]                   cfg_wdata,
    output logic [ADDR_W-1:0]                   base_a,
    output logic [ADDR_W-1:0]                   base_b,
    output logic [ADDR_W-1:0]                   base_c,
    output logic [MIRR_WORDS-1:0][DATA_W-1:0]   mirr_words
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << WINB_LOG2) - ADDR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_a <= '0;
            base_b <= '0;
            base_c <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_BASE_A) base_a <= cfg_wdata;
            if (cfg_addr == CFG_BASE_C) base_c <= cfg_wdata;
            if (cfg_addr == CFG_BASE_B) base_b <= cfg_wdata & PAGE_MASK;
        end
    end

    for (genvar gi = 0; gi < MIRR_WORDS; gi++) begin : g_mirr
        localparam logic [7:0] SLOT_ADDR = CFG_MIRR_LO + 8'(gi * 4);
        always_ff @(posedge clk) begin
            if (rst) begin
                mirr_words[gi] <= '0;
            end else if (cfg_we && cfg_addr == SLOT_ADDR) begin
                mirr_words[gi] <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/bwx_xlate.sv
module bwx_xlate
    import bwx_pkg::*;
#(
    parameter int OFFS_W = 12
) (
    input  logic [OFFS_W-1:0]   host_offs,
    input  logic                host_io,
    input  acc_size_e           host_size,
    input  logic [ADDR_W-1:0]   base_a,
    input  logic [ADDR_W-1:0]   base_b,
    input  logic [ADDR_W-1:0]   base_c,
    output xlate_t              xl
);

    logic [OFFS_W-1:0]  eff_offs;
    logic [OFFS_W-1:0]  rel_offs;
    logic [ADDR_W-1:0]  sel_base;
    logic [ADDR_W:0]    full_sum;
    logic [ADDR_W-1:0]  tgt;
    region_e            rgn;

    always_comb begin
        eff_offs = host_io ? {{(OFFS_W-8){1'b0}}, host_offs[7:0]} : host_offs;
    end

    always_comb begin
        if (eff_offs < OFFS_W'(WIN_A_END)) begin
            rgn      = RGN_A;
            sel_base = base_a;
            rel_offs = eff_offs;
        end else if (eff_offs < OFFS_W'(WIN_C_END)) begin
            rgn      = RGN_C;
            sel_base = base_c;
            rel_offs = eff_offs - OFFS_W'(WIN_A_END);
        end else if (eff_offs < OFFS_W'(MIRR_END)) begin
            rgn      = RGN_MIRR;
            sel_base = '0;
            rel_offs = eff_offs;
        end else begin
            rgn      = RGN_B;
            sel_base = base_b;
            rel_offs = eff_offs - OFFS_W'(MIRR_END);
        end
    end

    always_comb begin
        full_sum = {1'b0, sel_base} + (ADDR_W+1)'(rel_offs);
        tgt      = (rgn == RGN_MIRR) ? ADDR_W'(eff_offs) : full_sum[ADDR_W-1:0];
    end

    always_comb begin
        xl.rgn      = rgn;
        xl.addr     = tgt;
        xl.be       = lane_enables(host_size, tgt[1:0]);
        xl.mirr_idx = eff_offs[MIRR_IDX_W+1:2];
        xl.fault    = bad_shape(host_size, tgt[1:0])
                    | ((rgn != RGN_MIRR) && (full_sum >= TARGET_LIMIT));
    end

endmodule

// File: rtl/bwx_seq.sv
module bwx_seq
    import bwx_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                host_req,
    input  logic                                host_we,
    input  logic [DATA_W-1:0]                   host_wdata,
    input  xlate_t                              xl,
    input  logic [MIRR_WORDS-1:0][DATA_W-1:0]   mirr_words,
    output logic                                host_ack,
    output logic                                host_err,
    output logic [DATA_W-1:0]                   host_rdata,
    output logic                                ib_req,
    output logic                                ib_we,
    output logic [ADDR_W-1:0]                   ib_addr,
    output logic [BE_W-1:0]                     ib_be,
    output logic [DATA_W-1:0]                   ib_wdata,
    input  logic                                ib_ack,
    input  logic [DATA_W-1:0]                   ib_rdata
);

    typedef enum logic {ST_IDLE, ST_BUS} seq_state_e;

    seq_state_e state;
    logic       take;

    always_comb take = host_req && !host_ack && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            host_ack   <= 1'b0;
            host_err   <= 1'b0;
            host_rdata <= '0;
            ib_req     <= 1'b0;
            ib_we      <= 1'b0;
            ib_addr    <= '0;
            ib_be      <= '0;
            ib_wdata   <= '0;
        end else begin
            host_ack <= 1'b0;
            host_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        if (xl.fault) begin
                            host_ack   <= 1'b1;
                            host_err   <= 1'b1;
                            host_rdata <= '0;
                        end else if (xl.rgn == RGN_MIRR) begin
                            host_ack   <= 1'b1;
                            host_rdata <= host_we ? '0 : mirr_words[xl.mirr_idx];
                        end else begin
                            ib_req   <= 1'b1;
                            ib_we    <= host_we;
                            ib_addr  <= xl.addr;
                            ib_be    <= xl.be;
                            ib_wdata <= host_wdata;
                            state    <= ST_BUS;
                        end
                    end
                end
                ST_BUS: begin
                    if (ib_ack) begin
                        ib_req     <= 1'b0;
                        host_ack   <= 1'b1;
                        host_rdata <= ib_we ? '0 : ib_rdata;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bar_window_xlate.sv
module bar_window_xlate
    import bwx_pkg::*;
#(
    parameter int OFFS_W    = 12,
    parameter int WINB_LOG2 = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_req,
    input  logic                host_we,
    input  logic                host_io,
    input  logic [1:0]          host_size,
    input  logic [OFFS_W-1:0]   host_offs,
    input  logic [31:0]         host_wdata,
    output logic                host_ack,
    output logic                host_err,
    output logic [31:0]         host_rdata,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic                ib_req,
    output logic                ib_we,
    output logic [31:0]         ib_addr,
    output logic [3:0]          ib_be,
    output logic [31:0]         ib_wdata,
    input  logic                ib_ack,
    input  logic [31:0]         ib_rdata
);

    logic [ADDR_W-1:0]                  base_a;
    logic [ADDR_W-1:0]                  base_b;
    logic [ADDR_W-1:0]                  base_c;
    logic [MIRR_WORDS-1:0][DATA_W-1:0]  mirr_words;
    xlate_t                             xl;

    bwx_cfg_regs #(.WINB_LOG2(WINB_LOG2)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .base_a     (base_a),
        .base_b     (base_b),
        .base_c     (base_c),
        .mirr_words (mirr_words)
    );

    bwx_xlate #(.OFFS_W(OFFS_W)) u_xlate (
        .host_offs (host_offs),
        .host_io   (host_io),
        .host_size (acc_size_e'(host_size)),
        .base_a    (base_a),
        .base_b    (base_b),
        .base_c    (base_c),
        .xl        (xl)
    );

    bwx_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .xl         (xl),
        .mirr_words (mirr_words),
        .host_ack   (host_ack),
        .host_err   (host_err),
        .host_rdata (host_rdata),
        .ib_req     (ib_req),
        .ib_we      (ib_we),
        .ib_addr    (ib_addr),
        .ib_be      (ib_be),
        .ib_wdata   (ib_wdata),
        .ib_ack     (ib_ack),
        .ib_rdata   (ib_rdata)
    );

endmodule

// File: rtl/bwx_checker.sv
module bwx_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_req,
    input logic        host_ack,
    input logic        host_err,
    input logic        ib_req,
    input logic        ib_we,
    input logic [31:0] ib_addr,
    input logic [3:0]  ib_be,
    input logic [31:0] ib_wdata,
    input logic        ib_ack
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ib_req && !host_ack));

    a_r9_below_limit: assert property (@(posedge clk) disable iff (rst)
        ib_req |-> (ib_addr < 32'hC000_0000));

    a_r7_be_legal: assert property (@(posedge clk) disable iff (rst)
        ib_req |-> ($countones(ib_be) == 1 || ib_be == 4'b0011 ||
                    ib_be == 4'b1100 || ib_be == 4'b1111));

    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_be) &&
                                 $stable(ib_we) && $stable(ib_wdata)));

    a_r11_ack_follows: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ack) |=> (host_ack && !host_err && !ib_req));

    a_r11_launch_from_host: assert property (@(posedge clk) disable iff (rst)
        $rose(ib_req) |-> $past(host_req));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    a_r8_err_with_ack: assert property (@(posedge clk) disable iff (rst)
        host_err |-> host_ack);

endmodule

bind bar_window_xlate bwx_checker u_bwx_checker (
    .clk      (clk),
    .rst      (rst),
    .host_req (host_req),
    .host_ack (host_ack),
    .host_err (host_err),
    .ib_req   (ib_req),
    .ib_we    (ib_we),
    .ib_addr  (ib_addr),
    .ib_be    (ib_be),
    .ib_wdata (ib_wdata),
    .ib_ack   (ib_ack)
);

// File: tb/tb_bar_window_xlate.sv
module tb_bar_window_xlate;

    localparam int K_BUS = 0;
    localparam int K_MIR = 1;
    localparam int K_ERR = 2;

    typedef struct packed {
        logic [11:0] offs;
        logic [1:0]  size;
        logic        we;
        logic        io;
        logic [1:0]  kind;
        logic [31:0] exp;    // address for bus, data for mirror
        logic [3:0]  be;
        logic [3:0]  req;
    } vec_t;

    // bases: A=1000_0000, C=2000_0100, B written 3456_7ABC -> 3456_7000
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{12'h000, 2'd2, 1'b0, 1'b0, 2'd0, 32'h1000_0000, 4'hF, 4'd2},  // R2 first byte of A
        '{12'h056, 2'd1, 1'b0, 1'b0, 2'd0, 32'h1000_0056, 4'hC, 4'd2},  // R2 / R7 upper half
        '{12'h057, 2'd0, 1'b1, 1'b0, 2'd0, 32'h1000_0057, 4'h8, 4'd2},  // R2 last byte of A
        '{12'h058, 2'd2, 1'b0, 1'b0, 2'd0, 32'h2000_0100, 4'hF, 4'd3},  // R3 first byte of C
        '{12'h05F, 2'd0, 1'b0, 1'b0, 2'd0, 32'h2000_0107, 4'h8, 4'd3},  // R3 last byte of C
        '{12'h05A, 2'd1, 1'b1, 1'b0, 2'd0, 32'h2000_0102, 4'hC, 4'd3},  // R3 halfword
        '{12'h080, 2'd2, 1'b0, 1'b0, 2'd0, 32'h3456_7000, 4'hF, 4'd6},  // R6 aligned base B
        '{12'hFFD, 2'd0, 1'b0, 1'b0, 2'd0, 32'h3456_7F7D, 4'h2, 4'd5},  // R5 end of region
        '{12'h101, 2'd0, 1'b1, 1'b0, 2'd0, 32'h3456_7081, 4'h2, 4'd7},  // R7 byte lane 1
        '{12'h082, 2'd2, 1'b0, 1'b0, 2'd2, 32'h0,         4'h0, 4'd8},  // R8 misaligned word
        '{12'h011, 2'd1, 1'b0, 1'b0, 2'd2, 32'h0,         4'h0, 4'd8},  // R8 misaligned half
        '{12'h010, 2'd3, 1'b0, 1'b0, 2'd2, 32'h0,         4'h0, 4'd8},  // R8 reserved size
        '{12'hF84, 2'd2, 1'b0, 1'b1, 2'd0, 32'h3456_7004, 4'hF, 4'd10}, // R10 io path into B
        '{12'h710, 2'd1, 1'b0, 1'b1, 2'd0, 32'h1000_0010, 4'h3, 4'd10}, // R10 io path into A
        '{12'h064, 2'd2, 1'b0, 1'b0, 2'd1, 32'h5A00_0011, 4'h0, 4'd4}   // R4 mirror read
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic        host_io = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [11:0] host_offs = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic        host_err;
    logic [31:0] host_rdata;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ib_req;
    logic        ib_we;
    logic [31:0] ib_addr;
    logic [3:0]  ib_be;
    logic [31:0] ib_wdata;
    logic        ib_ack = 1'b0;
    logic [31:0] ib_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bar_window_xlate dut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_io(host_io),
        .host_size(host_size), .host_offs(host_offs), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_err(host_err), .host_rdata(host_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_be(ib_be),
        .ib_wdata(ib_wdata), .ib_ack(ib_ack), .ib_rdata(ib_rdata)
    );

    task automatic check(input bit ok, input int r, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s: got %h expected %h", r, what, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one host access with an emulated internal responder
    task automatic access(input logic [11:0] offs, input logic [1:0] size,
                          input logic we, input logic io, input logic [31:0] wd,
                          input int lat,
                          output bit bus_seen, output logic [31:0] b_addr,
                          output logic [3:0] b_be, output logic b_we,
                          output logic [31:0] b_wd, output bit acked,
                          output bit err, output logic [31:0] rd,
                          output bit early_ack);
        @(negedge clk);
        host_offs = offs; host_size = size; host_we = we; host_io = io;
        host_wdata = wd; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        bus_seen = 1'b0; acked = 1'b0; err = 1'b0; rd = '0; early_ack = 1'b0;
        b_addr = '0; b_be = '0; b_we = 1'b0; b_wd = '0;
        if (host_ack) begin
            acked = 1'b1; err = host_err; rd = host_rdata;
        end else if (ib_req) begin
            bus_seen = 1'b1;
            b_addr = ib_addr; b_be = ib_be; b_we = ib_we; b_wd = ib_wdata;
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                if (host_ack) early_ack = 1'b1;
            end
            ib_ack = 1'b1; ib_rdata = ~b_addr;
            @(negedge clk);
            ib_ack = 1'b0;
            acked = host_ack; err = host_err; rd = host_rdata;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit bs, ak, er, ea;
        logic [31:0] ba, bw, rdv;
        logic [3:0] bb;
        logic bwe;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!ib_req && !host_ack, 1, "idle after reset", {30'd0, ib_req, host_ack}, 32'd0);
        access(12'h010, 2'd2, 1'b0, 1'b0, '0, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(bs && ba == 32'h10, 1, "zero base A", ba, 32'h10);
        access(12'h080, 2'd2, 1'b0, 1'b0, '0, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(bs && ba == 32'h0, 1, "zero base B", ba, 32'h0);

        // R6 configuration load
        cfg_write(8'h40, 32'h1000_0000);
        cfg_write(8'h44, 32'h2000_0100);
        cfg_write(8'h48, 32'h3456_7ABC);
        for (int i = 0; i < 8; i++) cfg_write(8'h60 + 8'(i * 4), 32'h5A00_0000 + 32'(i * 17));

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].offs, VECS[v].size, VECS[v].we, VECS[v].io,
                   32'hA5A5_0000 + 32'(v), 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
            case (int'(VECS[v].kind))
                K_BUS: begin
                    check(bs && ba == VECS[v].exp, int'(VECS[v].req), "address", ba, VECS[v].exp);
                    check(bs && bb == VECS[v].be, 7, "byte enables", {28'd0, bb}, {28'd0, VECS[v].be});
                    check(ak && !er && bwe == VECS[v].we, 11, "completion", {30'd0, ak, er}, 32'd2);
                    if (VECS[v].we)
                        check(bw == 32'hA5A5_0000 + 32'(v), 11, "write data", bw, 32'hA5A5_0000 + 32'(v));
                    else
                        check(rdv == ~VECS[v].exp, 11, "read data", rdv, ~VECS[v].exp);
                end
                K_MIR: begin
                    check(!bs && ak && !er && rdv == VECS[v].exp, int'(VECS[v].req), "mirror read",
                          rdv, VECS[v].exp);
                end
                default: begin
                    check(!bs && ak && er, int'(VECS[v].req), "error response",
                          {30'd0, bs, er}, 32'd1);
                end
            endcase
        end

        // R4 mirror write ignored
        access(12'h064, 2'd2, 1'b1, 1'b0, 32'hDEAD_BEEF, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(!bs && ak && !er, 4, "mirror write local", {30'd0, bs, ak}, 32'd1);
        access(12'h064, 2'd2, 1'b0, 1'b0, '0, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(rdv == 32'h5A00_0011, 4, "mirror unchanged", rdv, 32'h5A00_0011);
        access(12'h07C, 2'd2, 1'b0, 1'b0, '0, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(!bs && rdv == 32'h5A00_0077, 4, "last mirror word", rdv, 32'h5A00_0077);

        // R11 slow acknowledge
        access(12'h020, 2'd2, 1'b0, 1'b0, '0, 3, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(bs && !ea && ak && rdv == ~32'h1000_0020, 11, "slow ack", rdv, ~32'h1000_0020);

        // R12 request while busy is dropped
        @(negedge clk);
        host_offs = 12'h030; host_size = 2'd2; host_we = 1'b0; host_io = 1'b0; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        ba = ib_addr;
        host_offs = 12'h040; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        ib_ack = 1'b1; ib_rdata = 32'h1234_5678;
        @(negedge clk);
        ib_ack = 1'b0;
        check(host_ack && ba == 32'h1000_0030, 12, "first access", ba, 32'h1000_0030);
        bs = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (ib_req || host_ack) bs = 1'b1;
        end
        check(!bs, 12, "dropped request", {31'd0, bs}, 32'd0);

        // R9 target limit
        cfg_write(8'h40, 32'hBFFF_FFF0);
        access(12'h00C, 2'd2, 1'b0, 1'b0, '0, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(bs && ba == 32'hBFFF_FFFC, 9, "just below limit", ba, 32'hBFFF_FFFC);
        access(12'h010, 2'd2, 1'b0, 1'b0, '0, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(!bs && ak && er, 9, "at limit", {30'd0, bs, er}, 32'd1);
        cfg_write(8'h44, 32'hFFFF_FFFC);
        access(12'h05C, 2'd2, 1'b0, 1'b0, '0, 0, bs, ba, bb, bwe, bw, ak, er, rdv, ea);
        check(!bs && ak && er, 9, "carry out", {30'd0, bs, er}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule